// File: doc/BRIEF.md
# Banked Level-Sensitive Interrupt Controller

This block gathers level-sensitive interrupt request lines from across a chip, in banks of 32, and turns them into one interrupt line to the processor. A parameter sets the bank count to three or four, which gives 96 or 128 sources. Each source can be enabled or disabled without a read-modify-write. Every bank has a write-one-to-clear port that enables sources and a write-one-to-set port that disables them. A per-bank pending view shows the sources that are both asserted and enabled.

When no selection is held, the controller latches the number of the lowest pending source into an active register. It keeps that number until software writes an acknowledge to the control register. An acknowledge also drops a selection whose source went away or was masked while it was held, so the interrupt handler cannot get stuck on it.

A soft reset, started from the configuration register, takes a fixed number of cycles and returns every register to its power-up value. A status bit reports when it has finished. Per-source level words and the threshold, idle and protection words are held as plain read/write storage, so that software can save and restore them. A revision word gives the major and minor version.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After reset every bank's mask word reads 0xFFFFFFFF, the active register (offset 0x40) reads 0, the status register (0x14) bit 0 reads 1 and `cpu_irq` is low.
- R2: Bank b has its mask word at 0x84+0x20*b, its enable port at 0x88+0x20*b and its disable port at 0x8C+0x20*b. Writing 1s to the enable port clears those mask bits, writing 1s to the disable port sets them, and 0 bits leave mask bits unchanged.
- R3: The pending word at 0x98+0x20*b reads source level AND NOT mask for its bank, with no edge latching. `cpu_irq` is high exactly when some source is both asserted and unmasked.
- R4: While no selection is held, the controller latches the lowest-numbered pending source into the active register (value in bits 6:0) on the next clock. A held number does not change until it is acknowledged, even if its source drops or is masked.
- R5: Writing a 1 in bit 0 of the control register (0x48) drops the held selection, so the active register reads 0. The next pending source is latched one clock later. A write with bit 0 clear does nothing.
- R6: Writing a 1 in bit 1 of the configuration register (0x10) starts a soft reset. During the soft reset, status bit 0 reads 0 and configuration bit 1 reads 1, and register writes are ignored. Once it finishes, status bit 0 reads 1 and all state is back at its R1/R8 reset values.
- R7: The revision register (0x00) reads the major version in bits 7:4 and the minor version in bits 3:0 (defaults 5 and 0, so 0x50).
- R8: The level word of source n sits at 0x100+4*n (8 bits), the threshold at 0x68 (8 bits), the idle word at 0x50 (2 bits) and protection at 0x4C (bit 0). Each reads back what was written, truncated to its width, and resets to 0.
- R9: Configuration bit 0 is an auto-idle enable. It reads back as written and resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | 10 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, available in the same cycle |
| src_lvl | input | NUM_BANKS*32 | Level-sensitive request lines |
| cpu_irq | output | 1 | Interrupt to the processor |

## Verification
Several request patterns are used. A group of neighbouring sources in one bank, with one of them left masked, separates masked from unmasked pending and checks the lowest-number choice. Dropping or masking a source while its number is held separates a latched selection from a live one, and shows that acknowledge clears a stale number. Two sources at opposite ends of the source range, asserted together, catch a wrong bank index or a wrong priority direction. A soft reset issued while a selection is held, with storage words set to non-zero values, shows that every piece of state returns to its reset value.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam int unsigned ADDR_W    = 10;
   localparam int unsigned BANK_W    = 32;
   localparam int unsigned MAX_BANKS = 4;

   localparam logic [ADDR_W-1:0] OFS_REV  = 10'h000;
   localparam logic [ADDR_W-1:0] OFS_CFG  = 10'h010;
   localparam logic [ADDR_W-1:0] OFS_STAT = 10'h014;
   localparam logic [ADDR_W-1:0] OFS_ACT  = 10'h040;
   localparam logic [ADDR_W-1:0] OFS_CTRL = 10'h048;
   localparam logic [ADDR_W-1:0] OFS_PROT = 10'h04C;
   localparam logic [ADDR_W-1:0] OFS_IDLE = 10'h050;
   localparam logic [ADDR_W-1:0] OFS_THR  = 10'h068;
   localparam logic [7:0]        LVL_WORD0 = 8'h40;   // 0x100 >> 2

   typedef enum logic [2:0] {
      BR_NONE,
      BR_MASK,
      BR_ENA,
      BR_DIS,
      BR_PEND
   } bank_reg_e;

   // Offset inside one 0x20-byte bank window
   function automatic bank_reg_e bank_reg_kind(input logic [4:0] low);
      case (low)
         5'h04:   return BR_MASK;
         5'h08:   return BR_ENA;
         5'h0C:   return BR_DIS;
         5'h18:   return BR_PEND;
         default: return BR_NONE;
      endcase
   endfunction
endpackage

// File: rtl/irqc_bank.sv
module irqc_bank #(
   parameter int unsigned WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_clr,
   input  logic             ena_we,
   input  logic             dis_we,
   input  logic [WIDTH-1:0] wdata,
   input  logic [WIDTH-1:0] src,
   output logic [WIDTH-1:0] mask_q,
   output logic [WIDTH-1:0] pend
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '1;
      end else if (soft_clr) begin
         mask_q <= '1;
      end else if (ena_we) begin
         mask_q <= mask_q & ~wdata;
      end else if (dis_we) begin
         mask_q <= mask_q | wdata;
      end
   end

   assign pend = src & ~mask_q;
endmodule

// File: rtl/irqc_select.sv
module irqc_select #(
   parameter int unsigned NSRC = 128,
   parameter int unsigned ID_W = 7
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            soft_clr,
   input  logic            ack,
   input  logic [NSRC-1:0] pend,
   output logic            act_valid,
   output logic [ID_W-1:0] act_num
);
   logic            found;
   logic [ID_W-1:0] low_idx;

   // Lowest index wins: scan downward so the last hit is the lowest
   always_comb begin
      found   = 1'b0;
      low_idx = '0;
      for (int i = NSRC - 1; i >= 0; i--) begin
         if (pend[i]) begin
            found   = 1'b1;
            low_idx = i[ID_W-1:0];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_valid <= 1'b0;
         act_num   <= '0;
      end else if (soft_clr || ack) begin
         act_valid <= 1'b0;
         act_num   <= '0;
      end else if (!act_valid && found) begin
         act_valid <= 1'b1;
         act_num   <= low_idx;
      end
   end
endmodule

// File: rtl/irqc_cfg.sv
module irqc_cfg #(
   parameter int unsigned NSRC       = 128,
   parameter int unsigned ID_W       = 7,
   parameter int unsigned LVL_W      = 8,
   parameter int unsigned THR_W      = 8,
   parameter int unsigned IDLE_W     = 2,
   parameter int unsigned RST_CYCLES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_cfg,
   input  logic              we_prot,
   input  logic              we_idle,
   input  logic              we_thr,
   input  logic              we_lvl,
   input  logic [ID_W-1:0]   lvl_idx,
   input  logic [31:0]       wdata,
   output logic              busy,
   output logic              autoidle,
   output logic              prot,
   output logic [IDLE_W-1:0] idle,
   output logic [THR_W-1:0]  thr,
   output logic [LVL_W-1:0]  lvl_rd
);
   localparam int unsigned CNT_W = $clog2(RST_CYCLES + 1);
   localparam logic [CNT_W-1:0] RST_LOAD = CNT_W'(RST_CYCLES);

   logic [CNT_W-1:0] rst_cnt;
   logic [LVL_W-1:0] lvl_q [NSRC];

   assign busy = (rst_cnt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_cnt  <= '0;
         autoidle <= 1'b0;
         prot     <= 1'b0;
         idle     <= '0;
         thr      <= '0;
      end else if (busy) begin
         rst_cnt  <= rst_cnt - 1'b1;
         autoidle <= 1'b0;
         prot     <= 1'b0;
         idle     <= '0;
         thr      <= '0;
      end else begin
         if (we_cfg) begin
            autoidle <= wdata[0];
            if (wdata[1]) rst_cnt <= RST_LOAD;
         end
         if (we_prot) prot <= wdata[0];
         if (we_idle) idle <= wdata[IDLE_W-1:0];
         if (we_thr)  thr  <= wdata[THR_W-1:0];
      end
   end

   for (genvar n = 0; n < NSRC; n++) begin : g_lvl
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lvl_q[n] <= '0;
         end else if (busy) begin
            lvl_q[n] <= '0;
         end else if (we_lvl && (lvl_idx == ID_W'(n))) begin
            lvl_q[n] <= wdata[LVL_W-1:0];
         end
      end
   end

   assign lvl_rd = lvl_q[lvl_idx];
endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl #(
   parameter int unsigned NUM_BANKS  = 4,
   parameter int unsigned LVL_W      = 8,
   parameter int unsigned THR_W      = 8,
   parameter int unsigned IDLE_W     = 2,
   parameter int unsigned RST_CYCLES = 4,
   parameter int unsigned REV_MAJOR  = 5,
   parameter int unsigned REV_MINOR  = 0,
   localparam int unsigned NSRC      = NUM_BANKS * irqc_pkg::BANK_W
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        bus_we,
   input  logic [irqc_pkg::ADDR_W-1:0] bus_addr,
   input  logic [31:0]                 bus_wdata,
   output logic [31:0]                 bus_rdata,
   input  logic [NSRC-1:0]             src_lvl,
   output logic                        cpu_irq
);
   import irqc_pkg::*;

   localparam int unsigned ID_W = $clog2(NSRC);
   localparam logic [MAX_BANKS-1:0] BANK_PRESENT = MAX_BANKS'((1 << NUM_BANKS) - 1);
   localparam logic [7:0] REV_WORD = {REV_MAJOR[3:0], REV_MINOR[3:0]};

   if (!(NUM_BANKS == 3 || NUM_BANKS == 4)) begin : g_bad_banks
      $error("NUM_BANKS must be 3 or 4");
   end
   if (RST_CYCLES < 1) begin : g_bad_rst
      $error("RST_CYCLES must be at least 1");
   end
   if (LVL_W < 1 || LVL_W > 32 || THR_W < 1 || THR_W > 32 || IDLE_W < 1 || IDLE_W > 32) begin : g_bad_w
      $error("storage widths must lie in 1..32");
   end
   if (REV_MAJOR > 15 || REV_MINOR > 15) begin : g_bad_rev
      $error("revision fields are 4 bits");
   end

   // Address decode
   logic            wr_ok, soft_clr;
   logic            in_bank, in_lvl;
   logic [1:0]      bsel;
   bank_reg_e       bkind;
   logic [7:0]      lvl_word;
   logic [ID_W-1:0] lvl_idx;

   assign wr_ok    = bus_we && !soft_clr;
   assign in_bank  = (bus_addr[9:7] == 3'b001);
   assign bsel     = bus_addr[6:5];
   assign bkind    = bank_reg_kind(bus_addr[4:0]);
   assign lvl_word = bus_addr[9:2] - LVL_WORD0;
   assign in_lvl   = (bus_addr[9:8] != 2'b00) && (bus_addr[1:0] == 2'b00)
                     && (32'(lvl_word) < NSRC);
   assign lvl_idx  = lvl_word[ID_W-1:0];

   logic ack;
   assign ack = wr_ok && (bus_addr == OFS_CTRL) && bus_wdata[0];

   // Banks
   logic [NSRC-1:0]   mask_all, pend_all;
   logic [BANK_W-1:0] mask_b [MAX_BANKS];
   logic [BANK_W-1:0] pend_b [MAX_BANKS];

   for (genvar b = 0; b < MAX_BANKS; b++) begin : g_bank
      if (b < NUM_BANKS) begin : g_live
         logic sel;
         assign sel = wr_ok && in_bank && (bsel == 2'(b));
         irqc_bank #(.WIDTH(BANK_W)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .soft_clr (soft_clr),
            .ena_we   (sel && (bkind == BR_ENA)),
            .dis_we   (sel && (bkind == BR_DIS)),
            .wdata    (bus_wdata),
            .src      (src_lvl[b*BANK_W +: BANK_W]),
            .mask_q   (mask_b[b]),
            .pend     (pend_b[b])
         );
         assign mask_all[b*BANK_W +: BANK_W] = mask_b[b];
         assign pend_all[b*BANK_W +: BANK_W] = pend_b[b];
      end else begin : g_absent
         assign mask_b[b] = '0;
         assign pend_b[b] = '0;
      end
   end

   assign cpu_irq = |pend_all;

   // Selection
   logic            act_valid;
   logic [ID_W-1:0] act_num;

   irqc_select #(.NSRC(NSRC), .ID_W(ID_W)) u_sel (
      .clk       (clk),
      .rst_n     (rst_n),
      .soft_clr  (soft_clr),
      .ack       (ack),
      .pend      (pend_all),
      .act_valid (act_valid),
      .act_num   (act_num)
   );

   // Configuration, soft reset and save/restore storage
   logic              autoidle, prot;
   logic [IDLE_W-1:0] idle;
   logic [THR_W-1:0]  thr;
   logic [LVL_W-1:0]  lvl_rd;

   irqc_cfg #(
      .NSRC(NSRC), .ID_W(ID_W), .LVL_W(LVL_W), .THR_W(THR_W),
      .IDLE_W(IDLE_W), .RST_CYCLES(RST_CYCLES)
   ) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .we_cfg   (wr_ok && (bus_addr == OFS_CFG)),
      .we_prot  (wr_ok && (bus_addr == OFS_PROT)),
      .we_idle  (wr_ok && (bus_addr == OFS_IDLE)),
      .we_thr   (wr_ok && (bus_addr == OFS_THR)),
      .we_lvl   (wr_ok && in_lvl),
      .lvl_idx  (lvl_idx),
      .wdata    (bus_wdata),
      .busy     (soft_clr),
      .autoidle (autoidle),
      .prot     (prot),
      .idle     (idle),
      .thr      (thr),
      .lvl_rd   (lvl_rd)
   );

   // Read path
   always_comb begin
      bus_rdata = '0;
      if (in_bank) begin
         if (BANK_PRESENT[bsel]) begin
            case (bkind)
               BR_MASK: bus_rdata = mask_b[bsel];
               BR_PEND: bus_rdata = pend_b[bsel];
               default: bus_rdata = '0;
            endcase
         end
      end else if (in_lvl) begin
         bus_rdata = 32'(lvl_rd);
      end else begin
         case (bus_addr)
            OFS_REV:  bus_rdata = 32'(REV_WORD);
            OFS_CFG:  bus_rdata = {30'b0, soft_clr, autoidle};
            OFS_STAT: bus_rdata = {31'b0, !soft_clr};
            OFS_ACT:  bus_rdata = 32'(act_num);
            OFS_PROT: bus_rdata = {31'b0, prot};
            OFS_IDLE: bus_rdata = 32'(idle);
            OFS_THR:  bus_rdata = 32'(thr);
            default:  bus_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
   parameter int unsigned NSRC = 128,
   parameter int unsigned ID_W = 7
) (
   input logic            clk,
   input logic            rst_n,
   input logic [NSRC-1:0] src_lvl,
   input logic [NSRC-1:0] mask_all,
   input logic            cpu_irq,
   input logic            ack,
   input logic            soft_clr,
   input logic            act_valid,
   input logic [ID_W-1:0] act_num
);
   AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq == (|(src_lvl & ~mask_all)));                               // R3

   AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (act_valid && !ack && !soft_clr) |=> (act_valid && $stable(act_num))); // R4

   AST_NEW_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (!act_valid && (|(src_lvl & ~mask_all)) && !ack && !soft_clr) |=> act_valid); // R4

   AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> (!act_valid && act_num == '0));                            // R5

   AST_SRST_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(soft_clr) |-> (&mask_all && !act_valid));                     // R6
endmodule

bind banked_irq_ctrl irqc_checker #(.NSRC(NSRC), .ID_W(ID_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .src_lvl   (src_lvl),
   .mask_all  (mask_all),
   .cpu_irq   (cpu_irq),
   .ack       (ack),
   .soft_clr  (soft_clr),
   .act_valid (act_valid),
   .act_num   (act_num)
);

// File: tb/banked_irq_ctrl_bench.sv
module banked_irq_ctrl_bench;
   localparam int NSRC = 128;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [9:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [NSRC-1:0] src_lvl = '0;
   logic        cpu_irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   banked_irq_ctrl u_banked_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_lvl(src_lvl), .cpu_irq(cpu_irq)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [9:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [9:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   function automatic logic [9:0] mask_a(input int b); return 10'(32'h84 + 32 * b); endfunction
   function automatic logic [9:0] ena_a (input int b); return 10'(32'h88 + 32 * b); endfunction
   function automatic logic [9:0] dis_a (input int b); return 10'(32'h8C + 32 * b); endfunction
   function automatic logic [9:0] pend_a(input int b); return 10'(32'h98 + 32 * b); endfunction

   task automatic t_reset_state();
      logic [31:0] d;
      for (int b = 0; b < 4; b++) begin
         rd(mask_a(b), d); chk("R1", "mask after reset", d, 32'hFFFF_FFFF);
      end
      rd(10'h040, d); chk("R1", "active after reset", d, 0);
      rd(10'h014, d); chk("R1", "status after reset", d, 1);
      chk("R1", "cpu_irq after reset", 32'(cpu_irq), 0);
      rd(10'h000, d); chk("R7", "revision", d, 32'h50);
   endtask

   task automatic t_mask_pend_select();
      logic [31:0] d;
      src_lvl[39:36] = 4'hF;                       // bank 1 bits 4..7
      rd(pend_a(1), d); chk("R3", "all masked pending", d, 0);
      chk("R3", "irq while masked", 32'(cpu_irq), 0);
      rd(10'h040, d); chk("R3", "no selection while masked", d, 0);
      wr(ena_a(1), 32'h0000_00E0);
      rd(mask_a(1), d); chk("R2", "enable port clears", d, 32'hFFFF_FF1F);
      rd(pend_a(1), d); chk("R3", "pending = level & ~mask", d, 32'h0000_00E0);
      chk("R3", "irq with pending", 32'(cpu_irq), 1);
      rd(10'h040, d); chk("R4", "lowest pending latched", d, 37);
      src_lvl[37] = 1'b0;
      rd(10'h040, d); chk("R4", "held after source drop", d, 37);
      wr(10'h048, 32'h0);
      rd(10'h040, d); chk("R5", "ack bit0 clear ignored", d, 37);
      wr(10'h048, 32'h1);
      rd(10'h040, d); chk("R5", "next after ack", d, 38);
      wr(dis_a(1), 32'h0000_0040);
      rd(mask_a(1), d); chk("R2", "disable port sets", d, 32'hFFFF_FF5F);
      rd(pend_a(1), d); chk("R3", "masked source leaves pending", d, 32'h0000_0080);
      rd(10'h040, d); chk("R4", "stale number held", d, 38);
      wr(10'h048, 32'h1);
      rd(10'h040, d); chk("R5", "stale cleared by ack", d, 39);
      src_lvl[39] = 1'b0;
      rd(pend_a(1), d); chk("R3", "dropped source leaves pending", d, 0);
      chk("R3", "irq low when nothing pending", 32'(cpu_irq), 0);
      wr(10'h048, 32'h1);
      rd(10'h040, d); chk("R5", "ack with nothing pending", d, 0);
      src_lvl = '0;
   endtask

   task automatic t_cross_bank();
      logic [31:0] d;
      wr(ena_a(0), 32'h0000_0004);
      wr(ena_a(3), 32'h8000_0000);
      src_lvl[127] = 1'b1; src_lvl[2] = 1'b1;
      rd(pend_a(3), d); chk("R3", "bank3 pending", d, 32'h8000_0000);
      rd(10'h040, d); chk("R4", "lowest across banks", d, 2);
      src_lvl[2] = 1'b0;
      wr(10'h048, 32'h1);
      rd(10'h040, d); chk("R4", "highest source selected", d, 127);
      src_lvl[127] = 1'b0;
      wr(10'h048, 32'h1);
      rd(10'h040, d); chk("R5", "cleared after last ack", d, 0);
   endtask

   task automatic t_storage();
      logic [31:0] d;
      wr(10'h100 + 10'(4 * 5), 32'hFFFF_FFA5);
      wr(10'h100 + 10'(4 * 127), 32'h0000_003C);
      wr(10'h068, 32'hFFFF_FFFF);
      wr(10'h050, 32'hFFFF_FFFF);
      wr(10'h04C, 32'hFFFF_FFFF);
      wr(10'h010, 32'h1);
      rd(10'h100 + 10'(4 * 5), d);   chk("R8", "level word 5", d, 32'hA5);
      rd(10'h100 + 10'(4 * 127), d); chk("R8", "level word 127", d, 32'h3C);
      rd(10'h100 + 10'(4 * 6), d);   chk("R8", "untouched level word", d, 0);
      rd(10'h068, d); chk("R8", "threshold width", d, 32'hFF);
      rd(10'h050, d); chk("R8", "idle width", d, 32'h3);
      rd(10'h04C, d); chk("R8", "protection width", d, 32'h1);
      rd(10'h010, d); chk("R9", "auto-idle readback", d, 32'h1);
   endtask

   task automatic t_soft_reset();
      logic [31:0] d;
      src_lvl[2] = 1'b1;                           // still enabled in bank 0
      rd(10'h040, d); chk("R4", "selection before soft reset", d, 2);
      wr(10'h010, 32'h2);
      rd(10'h014, d); chk("R6", "status busy", d, 0);
      rd(10'h010, d); chk("R6", "config bit1 while busy", d, 32'h2);
      wr(ena_a(2), 32'hFFFF_FFFF);                 // ignored while busy
      repeat (8) @(negedge clk);
      rd(10'h014, d); chk("R6", "status done", d, 1);
      for (int b = 0; b < 4; b++) begin
         rd(mask_a(b), d); chk("R6", "mask after soft reset", d, 32'hFFFF_FFFF);
      end
      rd(10'h040, d); chk("R6", "active after soft reset", d, 0);
      chk("R6", "irq after soft reset", 32'(cpu_irq), 0);
      rd(10'h100 + 10'(4 * 5), d); chk("R6", "level word cleared", d, 0);
      rd(10'h068, d); chk("R6", "threshold cleared", d, 0);
      rd(10'h04C, d); chk("R6", "protection cleared", d, 0);
      rd(10'h010, d); chk("R9", "auto-idle cleared", d, 0);
      src_lvl = '0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset_state();
      t_mask_pend_select();
      t_cross_bank();
      t_storage();
      t_soft_reset();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL R1..: watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule